// File: doc/BRIEF.md
# Multiplicative Frequency Boost Controller

This block keeps a boost frequency, in kHz, for one client watched by an activity monitor, and derives a target frequency from it. The monitor reports two kinds of event. One says that activity stayed above its upper watermark for consecutive periods. The other says that activity stayed below its lower watermark. An upper event multiplies the boost by an up coefficient (in percent) and adds a fixed step, and the result saturates at the maximum frequency. A lower event multiplies the boost by a down coefficient. When that result falls under half a step, the boost drops to zero. The block also drives the two enables that gate the monitor's consecutive-condition detectors. It closes the upper detector once the boost is saturated. It closes the lower detector once the boost reaches zero, unless a high average count keeps that detector open.

Each accepted request runs through a fixed sequence of operations on one shared serial divider. The sequence produces three results:
- the updated boost;
- a target built from the averaged activity count, the up threshold and the boost, with an optional frequency floor;
- the upper and lower raw watermarks for the present clock frequency.

The control is a state machine with these states:
- `ST_IDLE` waits for a request. An upper or lower event moves it to `ST_BOOST`, and an evaluate request moves it to `ST_AVG`.
- `ST_BOOST` waits for the boost quotient, then applies the saturate or snap rule and moves to `ST_AVG`.
- `ST_AVG` divides the count by the 12-unit sampling period and moves to `ST_COEF`.
- `ST_COEF` computes 10000 divided by the up threshold and moves to `ST_SCALE`.
- `ST_SCALE` forms the scaled target base and moves to `ST_WMUP`.
- `ST_WMUP` computes the upper watermark and moves to `ST_WMDN`.
- `ST_WMDN` computes the lower watermark and moves to `ST_FIN`.
- `ST_FIN` adds the boost, applies the floor and the dependency rule for the lower enable, pulses `done` and returns to `ST_IDLE`.

Top module: `boost_governor`

## Requirements
- R1: After reset, `boost`, `target`, `wm_upper` and `wm_lower` are 0, both `cons_up_en` and `cons_dn_en` are 1, and `busy` and `done` are 0.
- R2: An upper event first sets both enables to 1, then sets boost = floor(boost*up_coeff/100) + 16000. If that sum is at least `max_freq`, boost becomes `max_freq` and `cons_up_en` becomes 0.
- R3: A lower event first sets both enables to 1, then sets boost = floor(boost*dn_coeff/100). If that value is below 8000, boost becomes 0 and `cons_dn_en` becomes 0.
- R4: When `up_evt` and `dn_evt` are both high in the same idle cycle, only the upper update is applied.
- R5: At completion, target = floor(floor(floor(avg_count/12) * floor(10000/up_thr)) / 100) + boost, all in integer arithmetic.
- R6: If `dep_thr` is nonzero and `avg_count` >= `dep_thr`, the target is raised to at least `floor_freq` and `cons_dn_en` is forced to 1.
- R7: If `dep_thr` is nonzero, `avg_count` < `dep_thr` and the boost is 0, `cons_dn_en` is cleared. If `dep_thr` is 0, no floor or enable override applies.
- R8: At completion, wm_upper = floor(cur_freq*12*up_thr/100) and wm_lower = floor(cur_freq*12*dn_thr/100).
- R9: `busy` is high from the cycle after a request is accepted until completion. `done` is a one-cycle pulse, and every output result is valid in that cycle. An `eval` request recomputes the target and watermarks without changing the boost.
- R10: Events and `eval` requests that arrive while `busy` is high have no effect: the boost stays unchanged and no extra sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_evt | input | 1 | Consecutive-upper event strobe |
| dn_evt | input | 1 | Consecutive-lower event strobe |
| eval | input | 1 | Recompute target and watermarks only |
| avg_count | input | ACW (24) | Averaged activity count |
| dep_thr | input | ACW (24) | Average-dependency threshold; 0 disables it |
| floor_freq | input | FW (24) | Target floor in kHz |
| max_freq | input | FW (24) | Maximum frequency in kHz |
| cur_freq | input | FW (24) | Present clock frequency in kHz |
| up_coeff | input | UCW (10) | Growth coefficient, percent |
| dn_coeff | input | DCW (7) | Decay coefficient, percent, at most 100 |
| up_thr | input | THW (7) | Upper threshold, percent, nonzero |
| dn_thr | input | THW (7) | Lower threshold, percent |
| boost | output | FW (24) | Present boost in kHz |
| target | output | TW (32) | Target frequency in kHz |
| wm_upper | output | TW (32) | Upper raw watermark |
| wm_lower | output | TW (32) | Lower raw watermark |
| cons_up_en | output | 1 | Enable for the monitor's consecutive-upper detector |
| cons_dn_en | output | 1 | Enable for the monitor's consecutive-lower detector |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the inputs:
- All configuration inputs and `avg_count` hold steady while `busy` is high.
- `max_freq` only changes across a reset.
- `max_freq` is at least half a step.
- `up_thr` is nonzero and `dn_coeff` is at most 100, so the divider never sees a zero divisor and a decayed boost never grows.

The stimulus meets these assumptions. It changes configuration only between sequences, and it resets the block before each new coefficient set. It sweeps thresholds only over 1 to 100 and keeps values small enough that no intermediate product is truncated. Under these conditions the bench's integer model is exact.

// File: rtl/bgov_pkg.sv
package bgov_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BOOST,
        ST_AVG,
        ST_COEF,
        ST_SCALE,
        ST_WMUP,
        ST_WMDN,
        ST_FIN
    } bgov_state_e;

    localparam int unsigned PCT_SCALE     = 100;
    localparam int unsigned COEF_NUMER    = 10000;
    localparam int unsigned SAMPLE_PERIOD = 12;

endpackage

// File: rtl/bgov_div.sv
module bgov_div #(
    parameter int DW = 40,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] num,
    input  logic [VW-1:0] den,
    output logic [DW-1:0] quo,
    output logic [VW-1:0] rem,
    output logic          done
);
    localparam int CNTW = $clog2(DW + 1);

    logic [DW-1:0]   q_q;
    logic [VW-1:0]   r_q;
    logic [VW-1:0]   den_q;
    logic [CNTW-1:0] cnt_q;
    logic            run_q;
    logic            done_q;

    logic [VW:0]     shifted;
    logic [VW:0]     diff;
    logic            ge;
    logic [VW-1:0]   r_next;

    always_comb begin
        shifted = {r_q, q_q[DW-1]};
        ge      = (shifted >= {1'b0, den_q});
        diff    = shifted - {1'b0, den_q};
        r_next  = ge ? diff[VW-1:0] : shifted[VW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q    <= '0;
            r_q    <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                q_q   <= num;
                r_q   <= '0;
                den_q <= den;
                cnt_q <= CNTW'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                q_q   <= {q_q[DW-2:0], ge};
                r_q   <= r_next;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNTW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quo  = q_q;
    assign rem  = r_q;
    assign done = done_q;

    // R5: a finished division leaves a remainder smaller than the divisor
    a_r5_div_rem: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (r_q < den_q));

    // R9: the sequencer never launches a division while one is running
    a_r9_div_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run_q);

endmodule

// File: rtl/bgov_step.sv
module bgov_step #(
    parameter int FW       = 24,
    parameter int DW       = 40,
    parameter int STEP_KHZ = 16000
) (
    input  logic          go_up,
    input  logic [DW-1:0] q,
    input  logic [FW-1:0] max_freq,
    output logic [FW-1:0] boost_new,
    output logic          sat,
    output logic          zeroed
);
    localparam int HALF_STEP = STEP_KHZ / 2;

    logic [DW-1:0] grown;

    always_comb begin
        grown     = q + DW'(STEP_KHZ);
        boost_new = '0;
        sat       = 1'b0;
        zeroed    = 1'b0;
        if (go_up) begin
            if (grown >= DW'(max_freq)) begin
                boost_new = max_freq;
                sat       = 1'b1;
            end else begin
                boost_new = FW'(grown);
            end
        end else begin
            if (q < DW'(HALF_STEP)) begin
                boost_new = '0;
                zeroed    = 1'b1;
            end else begin
                boost_new = FW'(q);
            end
        end
    end

endmodule

// File: rtl/bgov_finish.sv
module bgov_finish #(
    parameter int FW  = 24,
    parameter int ACW = 24,
    parameter int TW  = 32
) (
    input  logic [TW-1:0]  base,
    input  logic [FW-1:0]  boost,
    input  logic [ACW-1:0] avg_count,
    input  logic [ACW-1:0] dep_thr,
    input  logic [FW-1:0]  floor_freq,
    input  logic           dn_en_in,
    output logic [TW-1:0]  tgt,
    output logic           dn_en_out
);
    logic [TW-1:0] sum;
    logic          dep_on;
    logic          above;

    always_comb begin
        sum       = base + TW'(boost);
        dep_on    = (dep_thr != '0);
        above     = dep_on && (avg_count >= dep_thr);
        tgt       = sum;
        dn_en_out = dn_en_in;
        if (above) begin
            dn_en_out = 1'b1;
            if (sum < TW'(floor_freq)) begin
                tgt = TW'(floor_freq);
            end
        end else if (dep_on && (boost == '0)) begin
            dn_en_out = 1'b0;
        end
    end

endmodule

// File: rtl/bgov_seq.sv
module bgov_seq
    import bgov_pkg::*;
#(
    parameter int FW  = 24,
    parameter int ACW = 24,
    parameter int TW  = 32,
    parameter int UCW = 10,
    parameter int DCW = 7,
    parameter int THW = 7,
    parameter int DW  = 40,
    parameter int VW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           up_evt,
    input  logic           dn_evt,
    input  logic           eval,
    input  logic [ACW-1:0] avg_count,
    input  logic [FW-1:0]  cur_freq,
    input  logic [UCW-1:0] up_coeff,
    input  logic [DCW-1:0] dn_coeff,
    input  logic [THW-1:0] up_thr,
    input  logic [THW-1:0] dn_thr,
    input  logic [FW-1:0]  step_boost,
    input  logic           step_sat,
    input  logic           step_zero,
    input  logic [TW-1:0]  fin_tgt,
    input  logic           fin_dn_en,
    input  logic [DW-1:0]  dv_quo,
    input  logic           dv_done,
    output logic           dv_start,
    output logic [DW-1:0]  dv_num,
    output logic [VW-1:0]  dv_den,
    output logic           mode_up,
    output logic [FW-1:0]  boost_q,
    output logic [TW-1:0]  base_q,
    output logic [TW-1:0]  target,
    output logic [TW-1:0]  wm_upper,
    output logic [TW-1:0]  wm_lower,
    output logic           cons_up_en,
    output logic           cons_dn_en,
    output logic           busy,
    output logic           done
);
    bgov_state_e   state_q;
    bgov_state_e   state_d;
    logic [DW-1:0] avg_div_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (up_evt || dn_evt) state_d = ST_BOOST;
                else if (eval)        state_d = ST_AVG;
            end
            ST_BOOST: if (dv_done) state_d = ST_AVG;
            ST_AVG:   if (dv_done) state_d = ST_COEF;
            ST_COEF:  if (dv_done) state_d = ST_SCALE;
            ST_SCALE: if (dv_done) state_d = ST_WMUP;
            ST_WMUP:  if (dv_done) state_d = ST_WMDN;
            ST_WMDN:  if (dv_done) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_start   <= 1'b0;
            dv_num     <= '0;
            dv_den     <= '0;
            mode_up    <= 1'b0;
            boost_q    <= '0;
            base_q     <= '0;
            avg_div_q  <= '0;
            target     <= '0;
            wm_upper   <= '0;
            wm_lower   <= '0;
            cons_up_en <= 1'b1;
            cons_dn_en <= 1'b1;
            done       <= 1'b0;
        end else begin
            dv_start <= 1'b0;
            done     <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (up_evt || dn_evt) begin
                        mode_up    <= up_evt;
                        cons_up_en <= 1'b1;
                        cons_dn_en <= 1'b1;
                        dv_num     <= DW'(boost_q) *
                                      (up_evt ? DW'(up_coeff) : DW'(dn_coeff));
                        dv_den     <= VW'(PCT_SCALE);
                        dv_start   <= 1'b1;
                    end else if (eval) begin
                        dv_num   <= DW'(avg_count);
                        dv_den   <= VW'(SAMPLE_PERIOD);
                        dv_start <= 1'b1;
                    end
                end
                ST_BOOST: begin
                    if (dv_done) begin
                        boost_q <= step_boost;
                        if (step_sat)  cons_up_en <= 1'b0;
                        if (step_zero) cons_dn_en <= 1'b0;
                        dv_num   <= DW'(avg_count);
                        dv_den   <= VW'(SAMPLE_PERIOD);
                        dv_start <= 1'b1;
                    end
                end
                ST_AVG: begin
                    if (dv_done) begin
                        avg_div_q <= dv_quo;
                        dv_num    <= DW'(COEF_NUMER);
                        dv_den    <= VW'(up_thr);
                        dv_start  <= 1'b1;
                    end
                end
                ST_COEF: begin
                    if (dv_done) begin
                        dv_num   <= avg_div_q * dv_quo;
                        dv_den   <= VW'(PCT_SCALE);
                        dv_start <= 1'b1;
                    end
                end
                ST_SCALE: begin
                    if (dv_done) begin
                        base_q   <= TW'(dv_quo);
                        dv_num   <= DW'(cur_freq) * DW'(SAMPLE_PERIOD) * DW'(up_thr);
                        dv_den   <= VW'(PCT_SCALE);
                        dv_start <= 1'b1;
                    end
                end
                ST_WMUP: begin
                    if (dv_done) begin
                        wm_upper <= TW'(dv_quo);
                        dv_num   <= DW'(cur_freq) * DW'(SAMPLE_PERIOD) * DW'(dn_thr);
                        dv_den   <= VW'(PCT_SCALE);
                        dv_start <= 1'b1;
                    end
                end
                ST_WMDN: begin
                    if (dv_done) wm_lower <= TW'(dv_quo);
                end
                ST_FIN: begin
                    target     <= fin_tgt;
                    cons_dn_en <= fin_dn_en;
                    done       <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

    // R4: simultaneous events take the upper path
    a_r4_up_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && up_evt && dn_evt) |=> (state_q == ST_BOOST && mode_up));

    // R10: once past the boost update, nothing disturbs the boost
    a_r10_boost_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_BOOST) |=> $stable(boost_q));

endmodule

// File: rtl/boost_governor.sv
module boost_governor #(
    parameter int FW       = 24,
    parameter int ACW      = 24,
    parameter int TW       = 32,
    parameter int UCW      = 10,
    parameter int DCW      = 7,
    parameter int THW      = 7,
    parameter int DW       = 40,
    parameter int VW       = 16,
    parameter int STEP_KHZ = 16000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           up_evt,
    input  logic           dn_evt,
    input  logic           eval,
    input  logic [ACW-1:0] avg_count,
    input  logic [ACW-1:0] dep_thr,
    input  logic [FW-1:0]  floor_freq,
    input  logic [FW-1:0]  max_freq,
    input  logic [FW-1:0]  cur_freq,
    input  logic [UCW-1:0] up_coeff,
    input  logic [DCW-1:0] dn_coeff,
    input  logic [THW-1:0] up_thr,
    input  logic [THW-1:0] dn_thr,
    output logic [FW-1:0]  boost,
    output logic [TW-1:0]  target,
    output logic [TW-1:0]  wm_upper,
    output logic [TW-1:0]  wm_lower,
    output logic           cons_up_en,
    output logic           cons_dn_en,
    output logic           busy,
    output logic           done
);
    localparam int HALF_STEP = STEP_KHZ / 2;

    logic          dv_start;
    logic [DW-1:0] dv_num;
    logic [VW-1:0] dv_den;
    logic [DW-1:0] dv_quo;
    logic [VW-1:0] dv_rem;
    logic          dv_done;
    logic          mode_up;
    logic [FW-1:0] step_boost;
    logic          step_sat;
    logic          step_zero;
    logic [TW-1:0] base_q;
    logic [TW-1:0] fin_tgt;
    logic          fin_dn_en;

    bgov_div #(.DW(DW), .VW(VW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dv_start),
        .num   (dv_num),
        .den   (dv_den),
        .quo   (dv_quo),
        .rem   (dv_rem),
        .done  (dv_done)
    );

    bgov_step #(.FW(FW), .DW(DW), .STEP_KHZ(STEP_KHZ)) u_step (
        .go_up     (mode_up),
        .q         (dv_quo),
        .max_freq  (max_freq),
        .boost_new (step_boost),
        .sat       (step_sat),
        .zeroed    (step_zero)
    );

    bgov_finish #(.FW(FW), .ACW(ACW), .TW(TW)) u_fin (
        .base       (base_q),
        .boost      (boost),
        .avg_count  (avg_count),
        .dep_thr    (dep_thr),
        .floor_freq (floor_freq),
        .dn_en_in   (cons_dn_en),
        .tgt        (fin_tgt),
        .dn_en_out  (fin_dn_en)
    );

    bgov_seq #(
        .FW(FW), .ACW(ACW), .TW(TW), .UCW(UCW), .DCW(DCW),
        .THW(THW), .DW(DW), .VW(VW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_evt     (up_evt),
        .dn_evt     (dn_evt),
        .eval       (eval),
        .avg_count  (avg_count),
        .cur_freq   (cur_freq),
        .up_coeff   (up_coeff),
        .dn_coeff   (dn_coeff),
        .up_thr     (up_thr),
        .dn_thr     (dn_thr),
        .step_boost (step_boost),
        .step_sat   (step_sat),
        .step_zero  (step_zero),
        .fin_tgt    (fin_tgt),
        .fin_dn_en  (fin_dn_en),
        .dv_quo     (dv_quo),
        .dv_done    (dv_done),
        .dv_start   (dv_start),
        .dv_num     (dv_num),
        .dv_den     (dv_den),
        .mode_up    (mode_up),
        .boost_q    (boost),
        .base_q     (base_q),
        .target     (target),
        .wm_upper   (wm_upper),
        .wm_lower   (wm_lower),
        .cons_up_en (cons_up_en),
        .cons_dn_en (cons_dn_en),
        .busy       (busy),
        .done       (done)
    );

    // R2: a closed upper detector means the boost sits at the maximum
    a_r2_up_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cons_up_en) |-> (boost == max_freq));

    // R3: a closed lower detector means the boost is zero
    a_r3_dn_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cons_dn_en) |-> (boost == '0));

    // R3: a settled boost is never a nonzero value below half a step
    a_r3_snap: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (boost == '0 || boost >= FW'(HALF_STEP)));

    // R9: completion is a single-cycle pulse outside a busy sequence
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/boost_governor_test.sv
`timescale 1ns/1ps
module boost_governor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_evt = 1'b0, dn_evt = 1'b0, eval = 1'b0;
    logic [23:0] avg_count = '0, dep_thr = '0, floor_freq = '0;
    logic [23:0] max_freq = '0, cur_freq = '0;
    logic [9:0]  up_coeff = '0;
    logic [6:0]  dn_coeff = '0, up_thr = 7'd1, dn_thr = 7'd1;
    logic [23:0] boost;
    logic [31:0] target, wm_upper, wm_lower;
    logic        cons_up_en, cons_dn_en, busy, done;

    int     total = 0;
    int     bad = 0;
    bit     finished = 0;
    longint m_boost;
    bit     m_upen, m_dnen;

    always #2 clk = ~clk;

    boost_governor uut (
        .clk(clk), .rst_n(rst_n), .up_evt(up_evt), .dn_evt(dn_evt), .eval(eval),
        .avg_count(avg_count), .dep_thr(dep_thr), .floor_freq(floor_freq),
        .max_freq(max_freq), .cur_freq(cur_freq), .up_coeff(up_coeff),
        .dn_coeff(dn_coeff), .up_thr(up_thr), .dn_thr(dn_thr), .boost(boost),
        .target(target), .wm_upper(wm_upper), .wm_lower(wm_lower),
        .cons_up_en(cons_up_en), .cons_dn_en(cons_dn_en), .busy(busy), .done(done)
    );

    task automatic chk(input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; up_evt = 0; dn_evt = 0; eval = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_boost = 0; m_upen = 1; m_dnen = 1;
        @(negedge clk);
    endtask

    task automatic model(input bit u, input bit d);
        longint dep = longint'(dep_thr);
        longint avg = longint'(avg_count);
        if (u || d) begin
            m_upen = 1; m_dnen = 1;
            if (u) begin
                m_boost = m_boost * longint'(up_coeff) / 100 + 16000;
                if (m_boost >= longint'(max_freq)) begin
                    m_boost = longint'(max_freq); m_upen = 0;
                end
            end else begin
                m_boost = m_boost * longint'(dn_coeff) / 100;
                if (m_boost < 8000) begin
                    m_boost = 0; m_dnen = 0;
                end
            end
        end
        if (dep != 0) begin
            if (avg >= dep) m_dnen = 1;
            else if (m_boost == 0) m_dnen = 0;
        end
    endtask

    function automatic longint exp_target();
        longint avg = longint'(avg_count);
        longint t = ((avg / 12) * (10000 / longint'(up_thr))) / 100 + m_boost;
        if (dep_thr != 0 && avg >= longint'(dep_thr) && t < longint'(floor_freq))
            t = longint'(floor_freq);
        return t;
    endfunction

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " boost"}, longint'(boost), m_boost);
        chk({tag, " cons_up_en"}, longint'(cons_up_en), longint'(m_upen));
        chk({tag, " R7 cons_dn_en"}, longint'(cons_dn_en), longint'(m_dnen));
        chk({tag, " R5 target"}, longint'(target), exp_target());
        chk({tag, " R8 wm_upper"}, longint'(wm_upper),
            longint'(cur_freq) * 12 * longint'(up_thr) / 100);
        chk({tag, " R8 wm_lower"}, longint'(wm_lower),
            longint'(cur_freq) * 12 * longint'(dn_thr) / 100);
        chk({tag, " R9 busy at done"}, longint'(busy), 0);
    endtask

    task automatic run(input bit u, input bit d, input bit e, input string tag);
        @(negedge clk);
        up_evt = u; dn_evt = d; eval = e;
        @(negedge clk);
        up_evt = 0; dn_evt = 0; eval = 0;
        model(u, d);
        wait_done();
        check_all(tag);
    endtask

    task automatic set_cfg(input int uc, input int dc, input int ut, input int dt,
                           input int dep, input int fl, input int mx, input int cf);
        up_coeff = 10'(uc); dn_coeff = 7'(dc); up_thr = 7'(ut); dn_thr = 7'(dt);
        dep_thr = 24'(dep); floor_freq = 24'(fl); max_freq = 24'(mx); cur_freq = 24'(cf);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R9 watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int avgs [7] = '{0, 11, 12, 1000, 600000, 3600000, 4799999};
        // R1: reset state
        set_cfg(200, 50, 60, 40, 0, 0, 400000, 300000);
        do_reset();
        chk("R1 boost", longint'(boost), 0);
        chk("R1 target", longint'(target), 0);
        chk("R1 wm", longint'(wm_upper) + longint'(wm_lower), 0);
        chk("R1 cons_up_en", longint'(cons_up_en), 1);
        chk("R1 cons_dn_en", longint'(cons_dn_en), 1);
        chk("R1 busy", longint'(busy), 0);
        chk("R1 done", longint'(done), 0);

        // R5/R9: eval over several averaged counts
        foreach (avgs[i]) begin
            avg_count = 24'(avgs[i]);
            run(0, 0, 1, "R9 eval");
        end
        // R2: growth to saturation
        for (int k = 0; k < 6; k++) begin
            avg_count = 24'(k * 250000);
            run(1, 0, 0, "R2 up");
        end
        // R3: decay to zero and beyond
        for (int k = 0; k < 10; k++) begin
            avg_count = 24'(k * 77777);
            run(0, 1, 0, "R3 down");
        end
        // R4: both events together
        run(1, 1, 0, "R4 both");
        run(1, 1, 0, "R4 both");

        // R10: requests during busy are ignored
        @(negedge clk); up_evt = 1;
        @(negedge clk); up_evt = 0; model(1, 0);
        repeat (5) @(negedge clk);
        chk("R9 busy during run", longint'(busy), 1);
        dn_evt = 1; eval = 1;
        @(negedge clk); dn_evt = 0; eval = 0;
        up_evt = 1;
        @(negedge clk); up_evt = 0;
        wait_done();
        check_all("R10 ignored");
        @(negedge clk);
        chk("R9 done one cycle", longint'(done), 0);
        repeat (3) @(negedge clk);
        chk("R10 no queued run", longint'(busy), 0);
        chk("R10 boost unchanged", longint'(boost), m_boost);

        // R8: threshold sweep
        avg_count = 24'd1234567;
        for (int t = 1; t <= 100; t++) begin
            up_thr = 7'(t); dn_thr = 7'(101 - t);
            run(0, 0, 1, "R8 sweep");
        end

        // R6/R7: dependency threshold set
        set_cfg(800, 90, 27, 10, 50000, 250000, 400000, 200000);
        do_reset();
        avg_count = 24'd49999; run(0, 0, 1, "R7 below dep");
        avg_count = 24'd50000; run(0, 0, 1, "R6 at dep");
        avg_count = 24'd0;     run(0, 0, 1, "R7 zero avg");
        avg_count = 24'd200000; run(0, 0, 1, "R6 floor");
        for (int k = 0; k < 3; k++) begin
            avg_count = 24'd10000;
            run(1, 0, 0, "R2 up dep");
        end
        for (int k = 0; k < 42; k++) begin
            avg_count = (k % 3 == 0) ? 24'd60000 : 24'd1000;
            run(0, 1, 0, "R6 R7 down dep");
        end
        avg_count = 24'd1000;  run(0, 0, 1, "R7 zero boost");
        avg_count = 24'd90000; run(0, 0, 1, "R6 force on");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule